// File: doc/BRIEF.md
# Instruction Packet Assembler with Loop-End Detection

This block takes 32-bit instruction words, one per cycle when the input strobe is high, and groups them into packets. A two-bit parse field inside each word says whether the word closes the packet, carries a hardware-loop-end marker, or holds a pair of compressed sub-instructions. For every accepted word the block reports its position in the packet, whether it is a compressed pair, and whether the word before it in the same packet was a constant extender.

When a packet closes, the block gives the word count, the size in bytes and a two-bit loop-end code. It builds the code from the markers on the first and second words, and it reads them according to the packet length. If the word limit is reached with no closing word, the block reports an incomplete packet with a zero byte size and starts a new packet with the next word. A decode stage that needs packet boundaries and loop-end information, but no full instruction decode, would use it.

Top module: `packet_assembler`

## Requirements
- R1: After reset, and in every cycle without a reported word or packet, all outputs are zero.
- R2: Each word accepted with `in_vld` high is reported one cycle later with `wd_vld` high and `wd_idx` giving its position in the packet (0 for the first word).
- R3: The parse field is `in_word[15:14]`. The value 3 closes the packet: in the same cycle that word is reported, `pk_done` is high and `pk_words` holds the number of words in the packet.
- R4: For a complete packet, `pk_bytes` equals four times `pk_words`.
- R5: A word whose parse field is 0 is reported with `wd_duplex` high. Any other parse value gives `wd_duplex` low.
- R6: A word whose bits [31:28] are 0 and whose parse field is not 0 is a constant extender. The next word of the same packet is reported with `wd_ext` high. The first word of a packet never has `wd_ext` high, even if the previous packet ended with an extender.
- R7: In a two-word packet, parse value 2 on word 0 gives `pk_loop` = 1 (loop 0 ends). Otherwise `pk_loop` = 0.
- R8: In a packet of three or more words, `pk_loop` is 3 when words 0 and 1 both carry parse value 2, 2 when only word 1 carries it, 1 when only word 0 carries it, and 0 when neither does.
- R9: Loop-end code 2 or 3 never appears for packets shorter than three words. Parse value 2 on words 2 and later does not change `pk_loop`.
- R10: When `MAX_WORDS` words arrive with no closing word, the last of them is reported with `pk_done` and `pk_short` high, `pk_words` = `MAX_WORDS`, `pk_bytes` = 0 and `pk_loop` = 0. The next word starts a new packet at index 0.
- R11: Cycles with `in_vld` low change no packet state. A packet that is interrupted by idle cycles continues where it left off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Word present on `in_word` this cycle |
| in_word | input | 32 | Instruction word |
| wd_vld | output | 1 | A word is reported this cycle |
| wd_idx | output | 2 | Position of the reported word in its packet |
| wd_ext | output | 1 | Reported word follows a constant extender |
| wd_duplex | output | 1 | Reported word is a compressed pair |
| pk_done | output | 1 | Packet closed with the reported word |
| pk_words | output | 3 | Words in the closed packet |
| pk_bytes | output | 5 | Byte size of the closed packet, 0 when incomplete |
| pk_loop | output | 2 | Loop-end code: 0 none, 1 loop 0, 2 loop 1, 3 both |
| pk_short | output | 1 | Packet hit the word limit without a closing word |

## Verification
The loop-end code is tried on packets of two, three and four words with markers on word 0 only, word 1 only, both words and neither word. This separates the length-dependent reading of the code and shows that a marker on a later word is ignored. Extender sequences show that the flag lands on the following word only, and that it neither crosses a packet boundary nor comes from a compressed pair whose upper bits happen to be zero. A run of four words with no closing word checks the incomplete report and the restart that follows it. A packet interrupted by idle cycles checks that the position count holds across gaps.

// File: rtl/pa_pkg.sv
// Shared constants and types for the packet assembler.
// Assumes the parse field is two bits wide.
package pa_pkg;
    localparam logic [1:0] PF_PAIR    = 2'd0;
    localparam logic [1:0] PF_LOOPMRK = 2'd2;
    localparam logic [1:0] PF_CLOSE   = 2'd3;

    typedef enum logic [1:0] {
        LC_NONE = 2'd0,
        LC_L0   = 2'd1,
        LC_L1   = 2'd2,
        LC_BOTH = 2'd3
    } loop_code_e;

    typedef struct packed {
        logic closes;
        logic loopmark;
        logic pair;
        logic extender;
    } word_info_t;
endpackage

// File: rtl/pa_field_decode.sv
// Classifies one instruction word from its parse field and top nibble.
// Assumes an extender has its top nibble at zero and a non-pair parse value.
module pa_field_decode
    import pa_pkg::*;
#(
    parameter int PF_LSB  = 14,
    parameter int EXT_LSB = 28
) (
    input  logic [31:0] word,
    output word_info_t  info
);
    logic [1:0] pf;
    assign pf = word[PF_LSB +: 2];

    // Derive the per-word classification flags.
    always_comb begin
        info.closes   = (pf == PF_CLOSE);
        info.loopmark = (pf == PF_LOOPMRK);
        info.pair     = (pf == PF_PAIR);
        info.extender = (word[EXT_LSB +: 4] == 4'h0) && (pf != PF_PAIR);
    end
endmodule

// File: rtl/pa_loop_encode.sv
// Turns the loop markers of words 0 and 1 into a loop-end code.
// Assumes the caller passes the final word count of the packet.
module pa_loop_encode
    import pa_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic [CW-1:0] nwords,
    input  logic          mark0,
    input  logic          mark1,
    input  logic          complete,
    output loop_code_e    code
);
    // Length-dependent reading of the markers.
    always_comb begin
        if (!complete)
            code = LC_NONE;
        else if (nwords >= CW'(3))
            code = loop_code_e'({mark1, mark0});
        else if (nwords == CW'(2))
            code = mark0 ? LC_L0 : LC_NONE;
        else
            code = LC_NONE;
    end
endmodule

// File: rtl/pa_tracker.sv
// Counts words within a packet, remembers the markers and extender state,
// and registers the per-word and per-packet reports.
// Assumes MAX_WORDS is at least 4 so words 0 and 1 both exist.
module pa_tracker
    import pa_pkg::*;
#(
    parameter int MAX_WORDS = 4,
    parameter int IW = $clog2(MAX_WORDS),
    parameter int CW = $clog2(MAX_WORDS + 1),
    parameter int BW = $clog2(4 * MAX_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  word_info_t    info,
    output logic          wd_vld,
    output logic [IW-1:0] wd_idx,
    output logic          wd_ext,
    output logic          wd_duplex,
    output logic          pk_done,
    output logic [CW-1:0] pk_words,
    output logic [BW-1:0] pk_bytes,
    output logic [1:0]    pk_loop,
    output logic          pk_short
);
    logic [IW-1:0] cnt;
    logic          prev_ext, mark0_q, mark1_q;
    logic          at_limit, finish, mark0_eff, mark1_eff;
    logic [CW-1:0] nwords;
    loop_code_e    code;

    assign at_limit  = (cnt == IW'(MAX_WORDS - 1));
    assign finish    = acc && (info.closes || at_limit);
    assign nwords    = CW'(cnt) + CW'(1);
    assign mark0_eff = (cnt == IW'(0)) ? info.loopmark : mark0_q;
    assign mark1_eff = (cnt == IW'(1)) ? info.loopmark : mark1_q;

    pa_loop_encode #(.CW(CW)) u_enc (
        .nwords   (nwords),
        .mark0    (mark0_eff),
        .mark1    (mark1_eff),
        .complete (info.closes),
        .code     (code)
    );

    // Packet position, extender and marker state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            prev_ext <= 1'b0;
            mark0_q  <= 1'b0;
            mark1_q  <= 1'b0;
        end else if (acc) begin
            if (finish) begin
                cnt      <= '0;
                prev_ext <= 1'b0;
                mark0_q  <= 1'b0;
                mark1_q  <= 1'b0;
            end else begin
                cnt      <= cnt + IW'(1);
                prev_ext <= info.extender;
                if (cnt == IW'(0)) mark0_q <= info.loopmark;
                if (cnt == IW'(1)) mark1_q <= info.loopmark;
            end
        end
    end

    // Registered per-word report, zero when no word was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n || !acc) begin
            wd_vld    <= 1'b0;
            wd_idx    <= '0;
            wd_ext    <= 1'b0;
            wd_duplex <= 1'b0;
        end else begin
            wd_vld    <= 1'b1;
            wd_idx    <= cnt;
            wd_ext    <= prev_ext;
            wd_duplex <= info.pair;
        end
    end

    // Registered per-packet report, zero except in the closing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !finish) begin
            pk_done  <= 1'b0;
            pk_words <= '0;
            pk_bytes <= '0;
            pk_loop  <= 2'd0;
            pk_short <= 1'b0;
        end else begin
            pk_done  <= 1'b1;
            pk_words <= nwords;
            pk_bytes <= info.closes ? BW'({nwords, 2'b00}) : '0;
            pk_loop  <= code;
            pk_short <= !info.closes;
        end
    end

    assert_short_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pk_short |-> (pk_done && pk_bytes == '0 && pk_words == CW'(MAX_WORDS) && pk_loop == 2'd0));
    assert_first_plain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_vld && wd_idx == '0) |-> !wd_ext);
    assert_loop1_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_done && pk_words < CW'(3)) |-> !pk_loop[1]);
    assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_vld && !pk_done) |=> (!wd_vld || wd_idx == $past(wd_idx) + IW'(1)));
    assert_done_with_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pk_done |-> wd_vld);
    assert_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_done && !pk_short) |-> (pk_bytes == BW'({pk_words, 2'b00})));
endmodule

// File: rtl/packet_assembler.sv
// Top of the packet assembler: classifies each incoming word and feeds the
// tracker that counts the packet and reports it.
// Assumes at most one word per cycle and MAX_WORDS of at least 4.
module packet_assembler
    import pa_pkg::*;
#(
    parameter int MAX_WORDS = 4,
    localparam int IW = $clog2(MAX_WORDS),
    localparam int CW = $clog2(MAX_WORDS + 1),
    localparam int BW = $clog2(4 * MAX_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [31:0]   in_word,
    output logic          wd_vld,
    output logic [IW-1:0] wd_idx,
    output logic          wd_ext,
    output logic          wd_duplex,
    output logic          pk_done,
    output logic [CW-1:0] pk_words,
    output logic [BW-1:0] pk_bytes,
    output logic [1:0]    pk_loop,
    output logic          pk_short
);
    word_info_t info;

    pa_field_decode #(.PF_LSB(14), .EXT_LSB(28)) u_dec (
        .word (in_word),
        .info (info)
    );

    pa_tracker #(.MAX_WORDS(MAX_WORDS), .IW(IW), .CW(CW), .BW(BW)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (in_vld),
        .info      (info),
        .wd_vld    (wd_vld),
        .wd_idx    (wd_idx),
        .wd_ext    (wd_ext),
        .wd_duplex (wd_duplex),
        .pk_done   (pk_done),
        .pk_words  (pk_words),
        .pk_bytes  (pk_bytes),
        .pk_loop   (pk_loop),
        .pk_short  (pk_short)
    );

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_vld) |-> (!wd_vld && !pk_done));
endmodule

// File: tb/packet_assembler_test.sv
`timescale 1ns/1ps
module packet_assembler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] in_word = 32'h0;
    logic        wd_vld, wd_ext, wd_duplex, pk_done, pk_short;
    logic [1:0]  wd_idx, pk_loop;
    logic [2:0]  pk_words;
    logic [4:0]  pk_bytes;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    packet_assembler uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
        .wd_vld(wd_vld), .wd_idx(wd_idx), .wd_ext(wd_ext), .wd_duplex(wd_duplex),
        .pk_done(pk_done), .pk_words(pk_words), .pk_bytes(pk_bytes),
        .pk_loop(pk_loop), .pk_short(pk_short)
    );

    // Build a word: parse value p; ext=1 zeroes the top nibble.
    function automatic logic [31:0] mk(input int p, input bit ext);
        return {ext ? 4'h0 : 4'hA, 12'h123, 2'(p), 14'h0ABC};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Send one word and check its report; packet fields checked when done.
    task automatic send(input logic [31:0] w, input int idx, input int ext,
                        input int dup, input int done, input int words,
                        input int bytes, input int lp, input int short_, input string tag);
        @(negedge clk);
        in_vld  = 1'b1;
        in_word = w;
        @(posedge clk);
        #2;
        in_vld = 1'b0;
        chk({tag, " R2 wd_vld"}, wd_vld, 1);
        chk({tag, " R2 wd_idx"}, wd_idx, idx);
        chk({tag, " R6 wd_ext"}, wd_ext, ext);
        chk({tag, " R5 wd_duplex"}, wd_duplex, dup);
        chk({tag, " R3 pk_done"}, pk_done, done);
        if (done != 0) begin
            chk({tag, " R3 pk_words"}, pk_words, words);
            chk({tag, " R4 pk_bytes"}, pk_bytes, bytes);
            chk({tag, " R8 pk_loop"}, pk_loop, lp);
            chk({tag, " R10 pk_short"}, pk_short, short_);
        end
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_vld = 1'b0;
        @(posedge clk);
        #2;
        chk({tag, " R11 wd_vld"}, wd_vld, 0);
        chk({tag, " R11 pk_done"}, pk_done, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #2;
        chk("R1 wd_vld", wd_vld, 0);
        chk("R1 pk_done", pk_done, 0);
        chk("R1 pk_bytes", pk_bytes, 0);
        chk("R1 pk_loop", pk_loop, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk("R1 idle after reset", wd_vld | pk_done | pk_short, 0);
    endtask

    task automatic t_single();
        send(mk(3, 0), 0, 0, 0, 1, 1, 4, 0, 0, "single R3");
    endtask

    task automatic t_two_word();
        send(mk(2, 0), 0, 0, 0, 0, 0, 0, 0, 0, "two loop0 R7");
        send(mk(3, 0), 1, 0, 0, 1, 2, 8, 1, 0, "two loop0 R7");
        send(mk(1, 0), 0, 0, 0, 0, 0, 0, 0, 0, "two none R7");
        send(mk(3, 0), 1, 0, 0, 1, 2, 8, 0, 0, "two none R7");
    endtask

    task automatic t_three_word();
        send(mk(1, 0), 0, 0, 0, 0, 0, 0, 0, 0, "three l1 R8");
        send(mk(2, 0), 1, 0, 0, 0, 0, 0, 0, 0, "three l1 R8");
        send(mk(3, 0), 2, 0, 0, 1, 3, 12, 2, 0, "three l1 R8");
        send(mk(2, 0), 0, 0, 0, 0, 0, 0, 0, 0, "three both R8");
        send(mk(2, 0), 1, 0, 0, 0, 0, 0, 0, 0, "three both R8");
        send(mk(3, 0), 2, 0, 0, 1, 3, 12, 3, 0, "three both R8");
        send(mk(1, 0), 0, 0, 0, 0, 0, 0, 0, 0, "three none R8");
        send(mk(1, 0), 1, 0, 0, 0, 0, 0, 0, 0, "three none R8");
        send(mk(2, 0), 2, 0, 0, 0, 0, 0, 0, 0, "three none R9");
        send(mk(3, 0), 3, 0, 0, 1, 4, 16, 0, 0, "four late mark R9");
    endtask

    task automatic t_four_word();
        send(mk(2, 0), 0, 0, 0, 0, 0, 0, 0, 0, "four l0 R8");
        send(mk(1, 0), 1, 0, 0, 0, 0, 0, 0, 0, "four l0 R8");
        send(mk(2, 0), 2, 0, 0, 0, 0, 0, 0, 0, "four l0 R9");
        send(mk(3, 0), 3, 0, 0, 1, 4, 16, 1, 0, "four l0 R9");
    endtask

    task automatic t_extender();
        send(mk(1, 1), 0, 0, 0, 0, 0, 0, 0, 0, "ext R6");
        send(mk(1, 0), 1, 1, 0, 0, 0, 0, 0, 0, "ext R6");
        send(mk(3, 1), 2, 0, 0, 1, 3, 12, 0, 0, "ext R6");
        send(mk(3, 0), 0, 0, 0, 1, 1, 4, 0, 0, "ext boundary R6");
    endtask

    task automatic t_duplex();
        send(mk(0, 1), 0, 0, 1, 0, 0, 0, 0, 0, "pair R5");
        send(mk(3, 0), 1, 0, 0, 1, 2, 8, 0, 0, "pair not ext R6");
    endtask

    task automatic t_incomplete();
        send(mk(2, 0), 0, 0, 0, 0, 0, 0, 0, 0, "short R10");
        send(mk(2, 0), 1, 0, 0, 0, 0, 0, 0, 0, "short R10");
        send(mk(1, 0), 2, 0, 0, 0, 0, 0, 0, 0, "short R10");
        send(mk(1, 1), 3, 0, 0, 1, 4, 0, 0, 1, "short R10");
        send(mk(3, 0), 0, 0, 0, 1, 1, 4, 0, 0, "after short R10");
    endtask

    task automatic t_gap();
        send(mk(2, 1), 0, 0, 0, 0, 0, 0, 0, 0, "gap R11");
        idle("gap");
        idle("gap");
        send(mk(3, 0), 1, 1, 0, 1, 2, 8, 1, 0, "gap R11");
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog R11 actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_two_word();
        t_three_word();
        t_four_word();
        t_extender();
        t_duplex();
        t_incomplete();
        t_gap();
        idle("end");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule